// File: doc/BRIEF.md
# Asymmetric Dual-Issue Dispatch Unit

This unit sits between an instruction fetch buffer and two execution pipelines. In every cycle it sees the two oldest fetched 32-bit instructions, an older one and a younger one. It decides whether both can leave together or only the older one. The two issue slots are not alike. One slot feeds the five-stage integer pipeline, and it takes ALU work, branches and every kind of load or store, including those that move floating-point data. The other slot feeds the seven-stage floating-point pipeline and takes only arithmetic: add, subtract, multiply-add, conversions and similar operations. A pair leaves together only when it holds exactly one instruction of each kind, the older one is not a branch, and the younger one does not read a floating-point register that the older one writes.

The fetch side is a valid/ready stream. `old_valid` and `young_valid` offer the instructions, and `consumed` is the ready answer. `consumed` is a combinational count of 0, 1 or 2. At the clock edge the fetch buffer must drop exactly that many instructions from its head, so a younger instruction that was left behind becomes the older one in the next cycle. Issue stays in program order. While `stall` is high, nothing is accepted and nothing issues. The chosen instructions appear one cycle later on registered slot outputs. Each carries a pipe tag for its position in program order.

Opcodes are the 6-bit primary field in bits 31:26. The COP1 format field is in bits 25:21. The function field is in bits 5:0.

Top module: `dual_issue_dispatch`

## Requirements
- R1: The following decode as integer class: opcodes 0x31, 0x35, 0x39 and 0x3D (FP loads and stores); opcode 0x11 with format 0, 1, 2, 4, 5, 6 or 8; opcode 0x13 with function bit 5 clear; and every opcode not listed in R2 or R7.
- R2: Opcode 0x11 with format 16, 17, 20 or 21, and opcode 0x13 with function bit 5 set, decode as FP-compute class.
- R3: When both instructions are valid and there is no stall, `consumed` is 2 if one instruction is integer class and the other is FP compute, in either order, and R5 and R6 do not forbid the pair.
- R4: Two integer-class instructions, or two FP-compute instructions, give `consumed` = 1.
- R5: `consumed` is 1 when the younger instruction reads an FP register that the older one writes. Writes are:
  - fd (bits 10:6) of FP arithmetic, except compares (function 0x30–0x3F), which write no FP register;
  - fd of opcode 0x13 multiply-adds and of its indexed loads (function 0 or 1);
  - rt (bits 20:16) of opcodes 0x31 and 0x35;
  - fs (bits 15:11) of format 4 or 5 moves.

  Reads are:
  - fs and ft of FP arithmetic;
  - fr (bits 25:21), fs and ft of multiply-adds;
  - rt of opcodes 0x39 and 0x3D;
  - fs of format 0 or 1 moves and of indexed stores (function 8 or 9).
- R6: An older branch never pairs, so `consumed` = 1. Branches are:
  - function 0x08 or 0x09 under opcode 0;
  - opcodes 0x01 to 0x07;
  - opcodes 0x14 to 0x17;
  - opcode 0x11 with format 8.
- R7: The following opcodes are unrecognised: 0x12, 0x1D, 0x1E, 0x1F, 0x32, 0x36, 0x3A, 0x3B and 0x3E, and also opcode 0x11 with any format not named in R1 or R2. An unrecognised instruction never pairs. An older one issues alone in the integer slot.
- R8: While `stall` is high, `consumed` is 0 and both slot valids are low in the next cycle.
- R9: With `old_valid` low, `consumed` is 0 whatever `young_valid` is.
- R10: In the cycle after a nonzero `consumed`:
  - `int_valid`/`int_insn` carry the issued integer-class or unrecognised instruction;
  - `fp_valid`/`fp_insn` carry the issued FP-compute instruction;
  - `old_pipe`/`young_pipe` give the pipe of the older and younger issued instruction (0 for the five-stage integer pipe, 1 for the seven-stage FP pipe).
- R11: During reset both slot valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| old_valid | input | 1 | Older instruction offered |
| old_insn | input | 32 | Older instruction word |
| young_valid | input | 1 | Younger instruction offered |
| young_insn | input | 32 | Younger instruction word |
| stall | input | 1 | Hold: issue nothing this cycle |
| consumed | output | 2 | Instructions accepted this cycle (0..2) |
| int_valid | output | 1 | Integer slot holds an issued instruction |
| int_insn | output | 32 | Integer slot instruction |
| fp_valid | output | 1 | FP slot holds an issued instruction |
| fp_insn | output | 32 | FP slot instruction |
| old_pipe | output | 1 | Pipe of the older issued instruction |
| young_pipe | output | 1 | Pipe of the younger issued instruction (paired cycles) |

## Verification
The assertions are checked on every cycle:
- a paired issue always fills both slots with different pipe tags;
- an older branch or an unrecognised instruction never lets the younger one through;
- a pair is never of one class;
- stall and a missing older instruction leave the slots empty in the next cycle.

The exact decode tables, the floating-point register hazard with its compare exception, and the routing of each instruction word into the correct slot can only be shown by the bench. The bench drives directed pairs and random pairs over a small register range to make hazards frequent, and compares the results against an independent model of the pairing rules.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int INSN_W  = 32;
  localparam int OP_W    = 6;
  localparam int FIELD_W = 5;
  localparam int FUNC_W  = 6;
  localparam int FP_REGS = 1 << FIELD_W;
  localparam int OP_LO   = INSN_W - OP_W;
  localparam int FMT_LO  = OP_LO - FIELD_W;
  localparam int FT_LO   = FMT_LO - FIELD_W;
  localparam int FS_LO   = FT_LO - FIELD_W;
  localparam int FD_LO   = FS_LO - FIELD_W;
  localparam int CNT_W   = 2;

  // FP format codes that mark arithmetic under the COP1 opcode
  localparam logic [FIELD_W-1:0] FMT_SGL = 5'd16;
  localparam logic [FIELD_W-1:0] FMT_DBL = 5'd17;
  localparam logic [FIELD_W-1:0] FMT_WRD = 5'd20;
  localparam logic [FIELD_W-1:0] FMT_LNG = 5'd21;

  localparam logic [OP_W-1:0] OPC_COP1  = 6'h11;
  localparam logic [OP_W-1:0] OPC_COP1X = 6'h13;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FPC = 2'd1,
    CLS_UNK = 2'd2
  } iclass_e;

  typedef enum logic {
    OPND_WRITE = 1'b0,
    OPND_READ  = 1'b1
  } opnd_kind_e;
endpackage

// File: rtl/insn_classifier.sv
module insn_classifier
  import dispatch_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output iclass_e           cls,
  output logic              is_branch
);
  logic [OP_W-1:0]    op;
  logic [FIELD_W-1:0] fmt;
  logic [FUNC_W-1:0]  fn;

  assign op  = insn[INSN_W-1 -: OP_W];
  assign fmt = insn[FMT_LO +: FIELD_W];
  assign fn  = insn[FUNC_W-1:0];

  always_comb begin
    cls       = CLS_INT;
    is_branch = 1'b0;
    unique case (op)
      6'h00: is_branch = (fn == 6'h08) || (fn == 6'h09);
      6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
      6'h14, 6'h15, 6'h16, 6'h17: is_branch = 1'b1;
      OPC_COP1: begin
        unique case (fmt)
          5'd0, 5'd1, 5'd2, 5'd4, 5'd5, 5'd6: cls = CLS_INT;
          5'd8: is_branch = 1'b1;
          FMT_SGL, FMT_DBL, FMT_WRD, FMT_LNG: cls = CLS_FPC;
          default: cls = CLS_UNK;
        endcase
      end
      OPC_COP1X: cls = fn[FUNC_W-1] ? CLS_FPC : CLS_INT;
      6'h12, 6'h1D, 6'h1E, 6'h1F, 6'h32, 6'h36,
      6'h3A, 6'h3B, 6'h3E: cls = CLS_UNK;
      default: cls = CLS_INT;
    endcase
  end
endmodule

// File: rtl/fp_operand_decode.sv
module fp_operand_decode
  import dispatch_pkg::*;
#(
  parameter opnd_kind_e KIND = OPND_WRITE
) (
  input  logic [INSN_W-1:0]  insn,
  output logic [FP_REGS-1:0] reg_mask
);
  logic [OP_W-1:0]    op;
  logic [FIELD_W-1:0] fr, ft, fs, fd;
  logic [FUNC_W-1:0]  fn;
  logic               arith;

  assign op = insn[INSN_W-1 -: OP_W];
  assign fr = insn[FMT_LO +: FIELD_W];
  assign ft = insn[FT_LO +: FIELD_W];
  assign fs = insn[FS_LO +: FIELD_W];
  assign fd = insn[FD_LO +: FIELD_W];
  assign fn = insn[FUNC_W-1:0];
  assign arith = (op == OPC_COP1) &&
                 (fr == FMT_SGL || fr == FMT_DBL || fr == FMT_WRD || fr == FMT_LNG);

  function automatic logic [FP_REGS-1:0] bit_of(input logic [FIELD_W-1:0] idx);
    return {{(FP_REGS-1){1'b0}}, 1'b1} << idx;
  endfunction

  generate
    if (KIND == OPND_WRITE) begin : g_dest
      always_comb begin
        reg_mask = '0;
        if (arith && fn[FUNC_W-1 -: 2] != 2'b11)                      reg_mask = bit_of(fd);
        else if (op == OPC_COP1 && (fr == 5'd4 || fr == 5'd5))        reg_mask = bit_of(fs);
        else if (op == OPC_COP1X && (fn[FUNC_W-1] || fn == 6'h00 || fn == 6'h01))
                                                                      reg_mask = bit_of(fd);
        else if (op == 6'h31 || op == 6'h35)                          reg_mask = bit_of(ft);
      end
    end else begin : g_src
      always_comb begin
        reg_mask = '0;
        if (arith)                                                    reg_mask = bit_of(fs) | bit_of(ft);
        else if (op == OPC_COP1 && (fr == 5'd0 || fr == 5'd1))        reg_mask = bit_of(fs);
        else if (op == OPC_COP1X && fn[FUNC_W-1])                     reg_mask = bit_of(fr) | bit_of(fs) | bit_of(ft);
        else if (op == OPC_COP1X && (fn == 6'h08 || fn == 6'h09))     reg_mask = bit_of(fs);
        else if (op == 6'h39 || op == 6'h3D)                          reg_mask = bit_of(ft);
      end
    end
  endgenerate
endmodule

// File: rtl/pair_checker.sv
module pair_checker
  import dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               old_valid,
  input  logic               young_valid,
  input  logic               stall,
  input  iclass_e            old_cls,
  input  iclass_e            young_cls,
  input  logic               old_branch,
  input  logic               young_branch,
  input  logic [FP_REGS-1:0] old_writes,
  input  logic [FP_REGS-1:0] young_reads,
  output logic               issue_old,
  output logic               issue_young,
  output logic [CNT_W-1:0]   consumed
);
  logic mixed, fp_raw;

  assign mixed  = (old_cls == CLS_INT && young_cls == CLS_FPC) ||
                  (old_cls == CLS_FPC && young_cls == CLS_INT);
  assign fp_raw = |(old_writes & young_reads);

  assign issue_old   = old_valid && !stall;
  assign issue_young = issue_old && young_valid && mixed && !old_branch && !fp_raw;
  assign consumed    = CNT_W'(issue_old) + CNT_W'(issue_young);

  // R6
  branch_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    old_branch |-> !issue_young);
  // R4
  same_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_young |-> old_cls != young_cls);
  // R7
  unknown_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (old_cls == CLS_UNK || young_cls == CLS_UNK) |-> !issue_young);
  // R1
  branch_is_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (old_branch || young_branch) |-> (old_branch ? old_cls == CLS_INT : young_cls == CLS_INT));
  // R9
  no_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !old_valid |-> consumed == '0);
endmodule

// File: rtl/issue_register.sv
module issue_register
  import dispatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_old,
  input  logic              issue_young,
  input  logic              old_fpc,
  input  logic              young_fpc,
  input  logic [INSN_W-1:0] old_insn,
  input  logic [INSN_W-1:0] young_insn,
  output logic              int_valid,
  output logic [INSN_W-1:0] int_insn,
  output logic              fp_valid,
  output logic [INSN_W-1:0] fp_insn,
  output logic              old_pipe,
  output logic              young_pipe
);
  logic int_take, fp_take;

  assign int_take = (issue_old && !old_fpc) || (issue_young && !young_fpc);
  assign fp_take  = (issue_old && old_fpc)  || (issue_young && young_fpc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_valid  <= 1'b0;
      fp_valid   <= 1'b0;
      int_insn   <= '0;
      fp_insn    <= '0;
      old_pipe   <= 1'b0;
      young_pipe <= 1'b0;
    end else begin
      int_valid <= int_take;
      fp_valid  <= fp_take;
      if (int_take) int_insn <= old_fpc ? young_insn : old_insn;
      if (fp_take)  fp_insn  <= old_fpc ? old_insn : young_insn;
      if (issue_old) begin
        old_pipe   <= old_fpc;
        young_pipe <= issue_young && young_fpc;
      end
    end
  end

  // R3
  pair_fills_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_young |=> int_valid && fp_valid);
  // R10
  pair_tags_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_young |=> old_pipe != young_pipe);
  // R8
  idle_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_old |=> !int_valid && !fp_valid);
  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_old && !issue_young) |=> int_valid != fp_valid);
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              old_valid,
  input  logic [INSN_W-1:0] old_insn,
  input  logic              young_valid,
  input  logic [INSN_W-1:0] young_insn,
  input  logic              stall,
  output logic [CNT_W-1:0]  consumed,
  output logic              int_valid,
  output logic [INSN_W-1:0] int_insn,
  output logic              fp_valid,
  output logic [INSN_W-1:0] fp_insn,
  output logic              old_pipe,
  output logic              young_pipe
);
  localparam int SLOTS = 2;

  logic [INSN_W-1:0] slot_insn [SLOTS];
  iclass_e           slot_cls  [SLOTS];
  logic              slot_br   [SLOTS];
  logic [FP_REGS-1:0] old_writes, young_reads;
  logic              issue_old, issue_young;

  assign slot_insn[0] = old_insn;
  assign slot_insn[1] = young_insn;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_cls
      insn_classifier u_cls (
        .insn      (slot_insn[s]),
        .cls       (slot_cls[s]),
        .is_branch (slot_br[s])
      );
    end
  endgenerate

  fp_operand_decode #(.KIND(OPND_WRITE)) u_old_dst (
    .insn     (old_insn),
    .reg_mask (old_writes)
  );

  fp_operand_decode #(.KIND(OPND_READ)) u_young_src (
    .insn     (young_insn),
    .reg_mask (young_reads)
  );

  pair_checker u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .old_valid    (old_valid),
    .young_valid  (young_valid),
    .stall        (stall),
    .old_cls      (slot_cls[0]),
    .young_cls    (slot_cls[1]),
    .old_branch   (slot_br[0]),
    .young_branch (slot_br[1]),
    .old_writes   (old_writes),
    .young_reads  (young_reads),
    .issue_old    (issue_old),
    .issue_young  (issue_young),
    .consumed     (consumed)
  );

  issue_register u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_old   (issue_old),
    .issue_young (issue_young),
    .old_fpc     (slot_cls[0] == CLS_FPC),
    .young_fpc   (slot_cls[1] == CLS_FPC),
    .old_insn    (old_insn),
    .young_insn  (young_insn),
    .int_valid   (int_valid),
    .int_insn    (int_insn),
    .fp_valid    (fp_valid),
    .fp_insn     (fp_insn),
    .old_pipe    (old_pipe),
    .young_pipe  (young_pipe)
  );
endmodule

// File: tb/sim_dual_issue_dispatch.sv
module sim_dual_issue_dispatch;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        old_valid = 1'b0, young_valid = 1'b0, stall = 1'b0;
  logic [31:0] old_insn = '0, young_insn = '0;
  logic [1:0]  consumed;
  logic        int_valid, fp_valid, old_pipe, young_pipe;
  logic [31:0] int_insn, fp_insn;

  dual_issue_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .old_valid(old_valid), .old_insn(old_insn),
    .young_valid(young_valid), .young_insn(young_insn), .stall(stall),
    .consumed(consumed), .int_valid(int_valid), .int_insn(int_insn),
    .fp_valid(fp_valid), .fp_insn(fp_insn), .old_pipe(old_pipe), .young_pipe(young_pipe)
  );

  typedef struct packed {
    int          req;
    logic [1:0]  cons;
    logic        iv;
    logic [31:0] ii;
    logic        fv;
    logic [31:0] fi;
    logic        op;
    logic        yp;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] a, input logic [4:0] b,
                                      input logic [4:0] c, input logic [4:0] d, input logic [5:0] f);
    return {op, a, b, c, d, f};
  endfunction

  // Independent model of the classes: 0 integer, 1 FP compute, 2 unrecognised
  function automatic int kind(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] fm = w[25:21];
    if (op inside {6'h12, 6'h1D, 6'h1E, 6'h1F, 6'h32, 6'h36, 6'h3A, 6'h3B, 6'h3E}) return 2;
    if (op == 6'h13) return w[5] ? 1 : 0;
    if (op == 6'h11) begin
      if (fm inside {5'd16, 5'd17, 5'd20, 5'd21}) return 1;
      if (fm inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd5, 5'd6, 5'd8}) return 0;
      return 2;
    end
    return 0;
  endfunction

  function automatic bit is_br(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == 6'h00) return w[5:0] == 6'h08 || w[5:0] == 6'h09;
    if (op inside {[6'h01:6'h07], [6'h14:6'h17]}) return 1;
    return op == 6'h11 && w[25:21] == 5'd8;
  endfunction

  function automatic logic [31:0] writes(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [31:0] m = '0;
    if (op == 6'h31 || op == 6'h35) m[w[20:16]] = 1'b1;
    if (op == 6'h11 && (w[25:21] == 5'd4 || w[25:21] == 5'd5)) m[w[15:11]] = 1'b1;
    if (op == 6'h11 && kind(w) == 1 && w[5:4] != 2'b11) m[w[10:6]] = 1'b1;
    if (op == 6'h13 && (w[5] || w[5:0] == 6'h00 || w[5:0] == 6'h01)) m[w[10:6]] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] reads(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [31:0] m = '0;
    if (op == 6'h39 || op == 6'h3D) m[w[20:16]] = 1'b1;
    if (op == 6'h11 && (w[25:21] == 5'd0 || w[25:21] == 5'd1)) m[w[15:11]] = 1'b1;
    if (op == 6'h11 && kind(w) == 1) begin m[w[15:11]] = 1'b1; m[w[20:16]] = 1'b1; end
    if (op == 6'h13 && w[5]) begin m[w[25:21]] = 1'b1; m[w[15:11]] = 1'b1; m[w[20:16]] = 1'b1; end
    if (op == 6'h13 && (w[5:0] == 6'h08 || w[5:0] == 6'h09)) m[w[15:11]] = 1'b1;
    return m;
  endfunction

  function automatic exp_t model(input int req, input logic ov, input logic [31:0] oi,
                                 input logic yv, input logic [31:0] yi, input logic st);
    exp_t e;
    int ko = kind(oi);
    int ky = kind(yi);
    bit pair;
    e = '0;
    e.req = req;
    if (st || !ov) return e;
    pair = yv && ((ko == 0 && ky == 1) || (ko == 1 && ky == 0)) && !is_br(oi) && ((writes(oi) & reads(yi)) == 0);
    e.cons = pair ? 2'd2 : 2'd1;
    e.op = (ko == 1);
    e.yp = pair && (ky == 1);
    if (ko == 1) begin e.fv = 1; e.fi = oi; end
    else         begin e.iv = 1; e.ii = oi; end
    if (pair) begin
      if (ky == 1) begin e.fv = 1; e.fi = yi; end
      else         begin e.iv = 1; e.ii = yi; end
    end
    return e;
  endfunction

  task automatic drive(input int req, input logic ov, input logic [31:0] oi,
                       input logic yv, input logic [31:0] yi, input logic st);
    exp_t e;
    @(negedge clk);
    old_valid = ov; old_insn = oi; young_valid = yv; young_insn = yi; stall = st;
    #1;
    e = model(req, ov, oi, yv, yi, st);
    check($sformatf("R%0d", req), "consumed", 32'(consumed), 32'(e.cons));
    q.push_back(e);
  endtask

  // Monitor: registered slot outputs one edge after each driven cycle
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      string r;
      e = q.pop_front();
      r = $sformatf("R%0d", e.req);
      check(r, "int_valid", 32'(int_valid), 32'(e.iv));
      check(r, "fp_valid", 32'(fp_valid), 32'(e.fv));
      if (e.iv) check(r, "int_insn (R10)", int_insn, e.ii);
      if (e.fv) check(r, "fp_insn (R10)", fp_insn, e.fi);
      if (e.cons != 0) check(r, "old_pipe (R10)", 32'(old_pipe), 32'(e.op));
      if (e.cons == 2) check(r, "young_pipe (R10)", 32'(young_pipe), 32'(e.yp));
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] add_i   = enc(6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20);
    logic [31:0] adds_f4 = enc(6'h11, 5'd16, 5'd6, 5'd2, 5'd4, 6'h00);
    logic [31:0] swc1_f4 = {6'h39, 5'd1, 5'd4, 16'h0008};
    logic [31:0] lwc1_f2 = {6'h31, 5'd1, 5'd2, 16'h0010};
    logic [31:0] adds_rd2 = enc(6'h11, 5'd16, 5'd6, 5'd2, 5'd8, 6'h00);
    logic [31:0] adds_ok  = enc(6'h11, 5'd16, 5'd12, 5'd10, 5'd8, 6'h00);
    logic [31:0] beq_i   = {6'h04, 5'd1, 5'd2, 16'h0010};
    logic [31:0] unk_i   = {6'h12, 26'h0};
    logic [31:0] madd_i  = enc(6'h13, 5'd1, 5'd2, 5'd3, 5'd5, 6'h20);
    logic [31:0] cvt_i   = enc(6'h11, 5'd20, 5'd0, 5'd7, 5'd6, 6'h20);
    logic [31:0] mtc1_f9 = enc(6'h11, 5'd4, 5'd1, 5'd9, 5'd0, 6'h00);
    logic [31:0] addd_r9 = enc(6'h11, 5'd17, 5'd9, 5'd3, 5'd1, 6'h00);
    logic [31:0] bc1_i   = {6'h11, 5'd8, 5'd1, 16'h0004};
    logic [31:0] cop1_bad = enc(6'h11, 5'd3, 5'd1, 5'd2, 5'd3, 6'h00);
    logic [31:0] ceq_i   = enc(6'h11, 5'd16, 5'd2, 5'd4, 5'd0, 6'h32);
    logic [31:0] swc1_f0 = {6'h39, 5'd1, 5'd0, 16'h0000};

    repeat (2) @(negedge clk);
    // R11: reset state
    check("R11", "int_valid in reset", 32'(int_valid), 32'd0);
    check("R11", "fp_valid in reset", 32'(fp_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(3, 1, add_i, 1, adds_f4, 0);        // R3 int then FP pairs
    drive(3, 1, adds_f4, 1, add_i, 0);        // R3 FP then int pairs
    drive(5, 1, adds_f4, 1, swc1_f4, 0);      // R5 store reads f4 written by older
    drive(5, 1, lwc1_f2, 1, adds_rd2, 0);     // R5 FP load feeds FP add
    drive(1, 1, lwc1_f2, 1, adds_ok, 0);      // R1 FP load is integer class, pairs
    drive(4, 1, add_i, 1, add_i, 0);          // R4 two integer
    drive(4, 1, adds_f4, 1, madd_i, 0);       // R4 two FP compute
    drive(6, 1, beq_i, 1, adds_ok, 0);        // R6 older branch alone
    drive(7, 1, unk_i, 1, adds_ok, 0);        // R7 unknown older alone, integer slot
    drive(7, 1, adds_ok, 1, unk_i, 0);        // R7 unknown younger not paired
    drive(7, 1, cop1_bad, 1, adds_ok, 0);     // R7 unknown COP1 format
    drive(8, 1, add_i, 1, adds_f4, 1);        // R8 stall
    drive(9, 0, add_i, 1, adds_f4, 0);        // R9 no older
    drive(2, 1, cvt_i, 1, add_i, 0);          // R2 conversion is FP compute
    drive(2, 1, add_i, 1, madd_i, 0);         // R2 multiply-add is FP compute
    drive(5, 1, mtc1_f9, 1, addd_r9, 0);      // R5 move to FP feeds FP add
    drive(6, 1, bc1_i, 1, adds_ok, 0);        // R6 FP branch alone
    drive(5, 1, ceq_i, 1, swc1_f0, 0);        // R5 compare writes no FP register

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w [2];
      for (int s = 0; s < 2; s++) begin
        logic [4:0] a = 5'($urandom_range(0, 3));
        logic [4:0] b = 5'($urandom_range(0, 3));
        logic [4:0] c = 5'($urandom_range(0, 3));
        case ($urandom_range(0, 9))
          0: w[s] = enc(6'h00, a, b, c, 5'd0, 6'h21);
          1: w[s] = enc(6'h11, 5'd17, a, b, c, 6'h01);
          2: w[s] = {6'h35, 5'd4, a, 16'h0020};
          3: w[s] = {6'h3D, 5'd4, a, 16'h0020};
          4: w[s] = {6'h05, a, b, 16'h0004};
          5: w[s] = enc(6'h13, a, b, c, a, 6'h29);
          6: w[s] = {6'h3B, 26'h0};
          7: w[s] = enc(6'h11, 5'd0, 5'd2, a, 5'd0, 6'h00);
          8: w[s] = enc(6'h11, 5'd16, a, b, 5'd0, 6'h3C);
          default: w[s] = enc(6'h11, 5'd21, 5'd0, a, b, 6'h20);
        endcase
      end
      // R3 random pairing against the model
      drive(3, ($urandom_range(0, 9) != 0), w[0], ($urandom_range(0, 7) != 0), w[1],
            ($urandom_range(0, 9) == 0));
    end
    @(negedge clk);
    old_valid = 0; young_valid = 0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule